// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block is the interrupt front end of a small microcontroller core. It watches two external request pins and a set of single-cycle event strobes from on-chip peripherals such as timer compare units. Each source owns a flag that is latched on the event itself. Flags combine with a per-source enable and a global enable. The block presents the vector address of the most urgent pending source to the core, together with a request line.

The core answers a request with a one-cycle acknowledge. On that acknowledge the block clears the serviced source's flag and drops the global enable in the same clock edge. A return-from-interrupt strobe or a software set strobe raises the global enable again, so handlers can allow nesting.

The two external sources are reached through a byte-wide I/O port. It has an enable register and a flag register. Writing a one to a flag bit clears that flag. Each external pin has a 2-bit sense selector for rising edge, falling edge or low level. In level mode the pin requests service directly and latches no flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, the enable register and the flag register both read 0x00, the global enable `gie` is 0 and `irq_req` is 0.
- R2: The enable register is at I/O address 0x3B, with the source 1 enable at bit 7 and the source 0 enable at bit 6. The flag register is at 0x3A, with the source 1 flag at bit 7 and the source 0 flag at bit 6. Bits 5..0 of both registers read zero, and any other address reads 0x00.
- R3: External sense code 2'b10 latches a flag on a falling pin edge. Code 2'b11 latches on a rising edge. Code 2'b01 never triggers. A pin change driven before a clock edge shows in the flag register after exactly three rising edges (two synchroniser stages plus the flag register) and not after two.
- R4: A flag is set only by a new event. After software clears it, it stays clear while the pin holds its triggering state.
- R5: Writing the flag register clears each external flag whose written bit is one. Bits written as zero leave their flag unchanged.
- R6: A flag latched while its enable is 0, or while `gie` is 0, stays latched. It raises `irq_req` once both enables are 1.
- R7: In sense code 2'b00 a low pin requests service (vector 1 for source 0, vector 2 for source 1), starting two rising edges after the pin falls. No flag is latched, and the request stops once the pin is high.
- R8: Vectors are 1 for source 0, 2 for source 1, and 3+k for peripheral strobe k. When several enabled sources are pending, `irq_vec` shows the lowest vector.
- R9: `irq_ack` while `irq_req` is high clears, at that edge, the flag of the source shown on `irq_vec` and clears `gie`.
- R10: `reti` or `gie_set` sets `gie` at the next edge. If `irq_ack` is taken in the same cycle, `gie` becomes 0.
- R11: Peripheral strobe k latches its flag, which requests service while `periph_en[k]` is 1. That flag is cleared only by an acknowledge of its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for `io_addr` (combinational) |
| ext_pin | input | 2 | Raw external request pins, bit 0 is source 0 |
| ext_sense | input | 4 | Sense codes, [1:0] for source 0 and [3:2] for source 1 |
| periph_evt | input | NUM_PERIPH | Single-cycle event strobes from peripherals |
| periph_en | input | NUM_PERIPH | Per-peripheral interrupt enables |
| gie_set | input | 1 | Software strobe that sets the global enable |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_ack | input | 1 | Core acknowledge of the presented vector |
| gie | output | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address of the winning source |

## Verification
Each result has its own fixed latency, and the bench samples it at exactly that point.

- **Register writes, acknowledges and strobes:** these land at the first rising edge after they are driven. The bench drives them just after a falling edge and reads the outcome one falling edge later.
- **Combinational outputs:** `irq_req` and `irq_vec` follow the state with no further register, so they are read in that same window.
- **External edges:** a pin edge needs three rising edges before its flag appears. The bench checks the flag register both after two edges (still clear) and after three (set).
- **Level requests:** a level request appears after two rising edges. The bench checks it after one edge (absent) and after two (present).

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam logic [5:0] ADDR_ENABLE = 6'h3B;
    localparam logic [5:0] ADDR_FLAGS  = 6'h3A;
    localparam logic [7:0] EXT_FIELD   = 8'hC0;   // bit 7: source 1, bit 6: source 0
    localparam int         NUM_EXT     = 2;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_NONE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic evt;   // edge event, sets the flag
        logic lvl;   // level request, bypasses the flag
    } pin_req_t;

    function automatic logic [7:0] ext_to_byte(input logic [1:0] v);
        return {v[1], v[0], 6'b0};
    endfunction

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  sense_e   mode,
    output pin_req_t req
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic [1:0] warm_q;   // counts until synchroniser and history hold real samples
    logic       live;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b00;
            prev_q <= 1'b0;
            warm_q <= 2'd0;
        end else begin
            sync_q <= {sync_q[0], pin};
            prev_q <= sync_q[1];
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        end
    end

    assign live = (warm_q == 2'd3);

    always_comb begin
        req = '0;
        if (live) begin
            unique case (mode)
                SENSE_FALL: req.evt = prev_q & ~sync_q[1];
                SENSE_RISE: req.evt = ~prev_q & sync_q[1];
                SENSE_LOW:  req.lvl = ~sync_q[1];
                default:    req = '0;
            endcase
        end
    end

    // R7
    level_mode_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LOW || mode == SENSE_NONE) |-> !req.evt);

    // R3
    edge_mode_no_level_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != SENSE_LOW) |-> !req.lvl);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         io_addr,
    input  logic               io_wr,
    input  logic [7:0]         io_wdata,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] hw_clr,
    output logic [NUM_SRC-1:0] flags,
    output logic [NUM_EXT-1:0] ext_en,
    output logic [7:0]         io_rdata
);
    logic [7:0]         enable_q;
    logic [NUM_SRC-1:0] sw_clr;
    logic               wr_flags;

    assign wr_flags = io_wr && (io_addr == ADDR_FLAGS);

    always_comb begin
        sw_clr = '0;
        if (wr_flags) begin
            sw_clr[0] = io_wdata[6];
            sw_clr[1] = io_wdata[7];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            enable_q <= 8'h00;
        end else begin
            flags <= (flags & ~sw_clr & ~hw_clr) | set_vec;
            if (io_wr && (io_addr == ADDR_ENABLE))
                enable_q <= io_wdata & EXT_FIELD;
        end
    end

    assign ext_en = {enable_q[7], enable_q[6]};

    always_comb begin
        unique case (io_addr)
            ADDR_ENABLE: io_rdata = ext_to_byte(ext_en);
            ADDR_FLAGS:  io_rdata = ext_to_byte(flags[1:0]);
            default:     io_rdata = 8'h00;
        endcase
    end

    // R4
    flag_only_on_event_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

    // R5
    write_one_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_flags)) |->
        ((flags[1:0] & {$past(io_wdata[7]), $past(io_wdata[6])} & ~$past(set_vec[1:0])) == 2'b00));

    // R2
    always_comb begin
        reserved_bits_zero_chk: assert (io_rdata[5:0] == 6'b0);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = 4,
    parameter int VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pending,
    input  logic               irq_ack,
    input  logic               reti,
    input  logic               gie_set,
    output logic               gie,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [NUM_SRC-1:0] clr_vec
);
    logic [NUM_SRC-1:0] grant;
    logic               taken;

    always_comb begin
        grant   = '0;
        irq_vec = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                irq_vec  = VEC_W'(i + 1);
            end
        end
    end

    assign irq_req = gie && (pending != '0);
    assign taken   = irq_ack && irq_req;
    assign clr_vec = taken ? grant : '0;

    always_ff @(posedge clk) begin
        if (rst)                  gie <= 1'b0;
        else if (taken)           gie <= 1'b0;
        else if (reti || gie_set) gie <= 1'b1;
    end

    // R9
    ack_drops_gie_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> !gie);

    // R10
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
        ((reti || gie_set) && !taken) |=> gie);

    // R9
    single_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

    // R8
    grant_is_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((grant & pending) != '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_PERIPH = 2,
    parameter int VEC_W      = $clog2(NUM_PERIPH + NUM_EXT + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [5:0]            io_addr,
    input  logic                  io_wr,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    input  logic [1:0]            ext_pin,
    input  logic [3:0]            ext_sense,
    input  logic [NUM_PERIPH-1:0] periph_evt,
    input  logic [NUM_PERIPH-1:0] periph_en,
    input  logic                  gie_set,
    input  logic                  reti,
    input  logic                  irq_ack,
    output logic                  gie,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vec
);
    localparam int NUM_SRC = NUM_EXT + NUM_PERIPH;

    pin_req_t           ext_req [NUM_EXT];
    logic [NUM_EXT-1:0] ext_evt;
    logic [NUM_EXT-1:0] ext_lvl;
    logic [NUM_EXT-1:0] ext_en;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] pending;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        irq_pin_detect u_det (
            .clk  (clk),
            .rst  (rst),
            .pin  (ext_pin[g]),
            .mode (sense_e'(ext_sense[2*g +: 2])),
            .req  (ext_req[g])
        );
        assign ext_evt[g] = ext_req[g].evt;
        assign ext_lvl[g] = ext_req[g].lvl;
    end

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .set_vec  ({periph_evt, ext_evt}),
        .hw_clr   (clr_vec),
        .flags    (flags),
        .ext_en   (ext_en),
        .io_rdata (io_rdata)
    );

    assign pending = (flags | {{NUM_PERIPH{1'b0}}, ext_lvl}) & {periph_en, ext_en};

    irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .irq_ack (irq_ack),
        .reti    (reti),
        .gie_set (gie_set),
        .gie     (gie),
        .irq_req (irq_req),
        .irq_vec (irq_vec),
        .clr_vec (clr_vec)
    );

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    localparam int NP    = 2;
    localparam int VEC_W = $clog2(NP + 3);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [5:0]       io_addr = 6'h00;
    logic             io_wr = 1'b0;
    logic [7:0]       io_wdata = 8'h00;
    logic [7:0]       io_rdata;
    logic [1:0]       ext_pin = 2'b11;
    logic [3:0]       ext_sense = 4'b0101;
    logic [NP-1:0]    periph_evt = '0;
    logic [NP-1:0]    periph_en = '0;
    logic             gie_set = 1'b0;
    logic             reti = 1'b0;
    logic             irq_ack = 1'b0;
    logic             gie;
    logic             irq_req;
    logic [VEC_W-1:0] irq_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl #(.NUM_PERIPH(NP)) u_dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .ext_pin(ext_pin), .ext_sense(ext_sense),
        .periph_evt(periph_evt), .periph_en(periph_en), .gie_set(gie_set),
        .reti(reti), .irq_ack(irq_ack), .gie(gie), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step();
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input int exp);
        io_addr = a;
        #1;
        check(req, int'(io_rdata), exp);
    endtask

    task automatic pulse_gie_set();
        gie_set = 1'b1; step(); gie_set = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    // vector expected for peripheral flags and enables: lowest enabled index wins
    function automatic int exp_vec(input logic [NP-1:0] f, input logic [NP-1:0] e);
        for (int k = 0; k < NP; k++)
            if (f[k] && e[k]) return 3 + k;
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] m_flags;
        logic          m_gie;
        logic [NP-1:0] evt;
        logic [NP-1:0] en;
        int            v;
        void'($urandom(32'd4242));

        step(3);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd_chk("R1 enable reg", 6'h3B, 0);
        rd_chk("R1 flag reg", 6'h3A, 0);
        check("R1 gie", gie, 0);
        check("R1 irq_req", irq_req, 0);
        step(4);

        // R2 register map
        wr(6'h3B, 8'hFF);
        rd_chk("R2 enable reserved bits", 6'h3B, 8'hC0);
        wr(6'h3B, 8'h40);
        rd_chk("R2 enable bit6", 6'h3B, 8'h40);
        rd_chk("R2 other addr", 6'h10, 0);

        // R3 falling edge on source 0, exact latency
        ext_sense[1:0] = 2'b10;
        ext_pin[0] = 1'b0;
        step(2); rd_chk("R3 falling not yet", 6'h3A, 0);
        step(1); rd_chk("R3 falling latched", 6'h3A, 8'h40);
        // R6 latched while gie is 0
        check("R6 no req with gie 0", irq_req, 0);

        // R4 clear while pin stays low
        wr(6'h3A, 8'h40);
        step(5); rd_chk("R4 stays clear", 6'h3A, 0);

        // R5 write zero keeps, write one clears
        ext_pin[0] = 1'b1; step(3);
        ext_pin[0] = 1'b0; step(3);
        wr(6'h3A, 8'h80);
        rd_chk("R5 zero bit keeps flag", 6'h3A, 8'h40);
        wr(6'h3A, 8'h40);
        rd_chk("R5 one bit clears flag", 6'h3A, 0);
        ext_pin[0] = 1'b1; step(3);
        ext_pin[0] = 1'b0; step(3);
        rd_chk("R4 new event sets again", 6'h3A, 8'h40);

        // R6 / R9 service source 0
        pulse_gie_set();
        check("R6 req after gie", irq_req, 1);
        check("R8 vector src0", irq_vec, 1);
        pulse_ack();
        check("R9 gie cleared", gie, 0);
        check("R9 req dropped", irq_req, 0);
        rd_chk("R9 flag cleared", 6'h3A, 0);

        // R3 rising mode on source 1
        ext_sense[3:2] = 2'b11;
        ext_pin[1] = 1'b0; step(3);
        rd_chk("R3 rising ignores fall", 6'h3A, 0);
        ext_pin[1] = 1'b1; step(3);
        rd_chk("R3 rising latched", 6'h3A, 8'h80);
        pulse_gie_set();
        check("R6 masked source no req", irq_req, 0);
        wr(6'h3B, 8'hC0);
        check("R6 req after enable", irq_req, 1);
        check("R8 vector src1", irq_vec, 2);
        ext_pin[0] = 1'b1; step(3);
        ext_pin[0] = 1'b0; step(3);
        check("R8 src0 wins over src1", irq_vec, 1);
        pulse_ack();
        rd_chk("R9 only winner cleared", 6'h3A, 8'h80);
        check("R9 req off after ack", irq_req, 0);
        pulse_reti();
        check("R10 reti sets gie", gie, 1);
        check("R8 remaining src1", irq_vec, 2);
        pulse_ack();
        rd_chk("R9 src1 cleared", 6'h3A, 0);

        // R11 peripheral strobe, R10 ack wins over reti
        periph_en = 2'b01;
        periph_evt = 2'b01; step(); periph_evt = '0;
        check("R11 no req gie 0", irq_req, 0);
        pulse_gie_set();
        check("R11 periph req", irq_req, 1);
        check("R11 periph vector", irq_vec, 3);
        irq_ack = 1'b1; reti = 1'b1; step(); irq_ack = 1'b0; reti = 1'b0;
        check("R10 ack wins", gie, 0);
        pulse_gie_set();
        check("R11 periph flag cleared", irq_req, 0);

        // R7 level mode on source 0
        ext_pin[0] = 1'b1; step(3);
        ext_sense[1:0] = 2'b00;
        step(1);
        check("R7 high pin no req", irq_req, 0);
        ext_pin[0] = 1'b0;
        step(1); check("R7 not yet", irq_req, 0);
        step(1); check("R7 level req", irq_req, 1);
        check("R7 level vector", irq_vec, 1);
        rd_chk("R7 no flag", 6'h3A, 0);
        pulse_ack();
        check("R7 ack drops req", irq_req, 0);
        pulse_reti();
        check("R7 still low requests", irq_req, 1);
        ext_pin[0] = 1'b1; step(2);
        check("R7 released", irq_req, 0);

        // R3 reserved code never triggers
        ext_sense[1:0] = 2'b01;
        ext_pin[0] = 1'b0; step(3);
        rd_chk("R3 reserved no flag", 6'h3A, 0);
        ext_pin[0] = 1'b1; step(3);
        rd_chk("R3 reserved no flag rise", 6'h3A, 0);
        check("R3 reserved no req", irq_req, 0);

        // random peripheral traffic: R8 R11 R6
        m_flags = '0;
        m_gie = gie;
        for (int it = 0; it < 60; it++) begin
            evt = NP'($urandom);
            en  = NP'($urandom);
            periph_evt = evt; periph_en = en;
            step();
            periph_evt = '0;
            m_flags = m_flags | evt;
            if (($urandom % 3) != 0) begin
                pulse_gie_set();
                m_gie = 1'b1;
            end
            v = exp_vec(m_flags, en);
            check("R11 random req", irq_req, (m_gie && v != 0) ? 1 : 0);
            if (m_gie && v != 0) begin
                check("R8 random vector", irq_vec, v);
                pulse_ack();
                m_flags[v-3] = 1'b0;
                m_gie = 1'b0;
                check("R9 random gie", gie, 0);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule